// File: doc/BRIEF.md
# OOK Wake-up Call Transmitter

This block turns one wake-up call into an on-off-keyed bit stream on a single keying output. A host presents a target address, two rate codes, a flag byte and a six-byte payload, then pulses `start`. The transmitter latches everything in that cycle. It sends a fixed alternating preamble at the slow rate, then the 16-bit address at the fast rate. When the flag requests it, the six payload bytes follow, also at the fast rate.

Bit timing comes from an internal divider on the system clock. The slowest supported rate lasts `2**BASE_LOG2` clock cycles per bit, and each step up in the rate code halves that period. A rate code outside the supported range is refused with a one-cycle error pulse, and nothing is sent. While a call is in flight, `busy` is high and further start requests are ignored. `done` marks the end of the call.

Top module: `ook_wuc_tx`

## Requirements
- R1: Rate code 0x02 gives a bit period of `2**BASE_LOG2` clock cycles. Each code from 0x03 through 0x07 halves the period of the code below it, so the codes map to 1024, 2048, 4096, 8192, 16384 and 32768 bit/s when the clock runs at 1024·2**BASE_LOG2 Hz.
- R2: If `start` arrives while idle and either rate code lies outside 0x02..0x07, `rate_err` is high for exactly one cycle, in the cycle after `start`. In that case `busy` stays low and `key_out` stays low.
- R3: An accepted call begins with PRE_LEN preamble bits at the low rate, alternating and starting with 1. The 16 address bits follow at the fast rate, most significant bit first.
- R4: The payload is sent only when bit 0 of `pay_flags` is 1. The other flag bits have no effect. The payload is 48 bits at the fast rate, starting with byte `pay_data[47:40]`, each byte MSB first. When bit 0 is 0, the call ends after the address whatever `pay_data` holds.
- R5: `key_out` is high for a 1 bit and low for a 0 bit, and it is low whenever `busy` is low.
- R6: `busy` rises in the cycle after an accepted `start` and stays high until the last bit period has ended.
- R7: A `start` while `busy` is high has no effect. It raises no `rate_err`, and the running call keeps its latched address, rates, flag and payload.
- R8: `done` is high for exactly one cycle, in the first cycle after the last bit, with `busy` and `key_out` low. A `start` during that cycle is accepted.
- R9: During and right after reset, `key_out`, `busy`, `done` and `rate_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one call |
| tgt_addr | input | 16 | Target wake-up address |
| rate_low | input | 8 | Rate code for the preamble |
| rate_fast | input | 8 | Rate code for address and payload |
| pay_flags | input | 8 | Bit 0 requests the payload |
| pay_data | input | 48 | Six payload bytes, first byte in [47:40] |
| key_out | output | 1 | On-off keying output |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle end-of-call pulse |
| rate_err | output | 1 | One-cycle pulse on a refused rate code |

## Verification
The bench aims at the seam where the period switches from the slow preamble rate to the fast address rate, and runs crossed rate pairs (slowest/fastest and the reverse). A divider that keeps the old period one bit too long would show up there as a stretched or shifted address bit. It sends calls whose flag byte has every bit but bit 0 set and a non-zero payload. A design that tests the wrong flag bit would append 48 unexpected bits. Refused codes on both sides of the valid range (0x00, 0x01, 0x08, 0xFF) must give an error pulse and no output. Starts injected mid-call, with illegal and then with new legal settings, would cause a spurious error or a corrupted frame if the latching were missing. A start placed in the `done` cycle would be lost by a design that holds off one cycle too long.

// File: rtl/ook_wuc_pkg.sv
package ook_wuc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ADDR = 2'd2,
    ST_PAY  = 2'd3
  } tx_state_e;

  localparam logic [7:0] RATE_CODE_MIN = 8'h02;
  localparam logic [7:0] RATE_CODE_MAX = 8'h07;

  // A code is usable when it selects one of the supported power-of-two rates.
  function automatic logic rate_code_ok(input logic [7:0] code);
    return (code >= RATE_CODE_MIN) && (code <= RATE_CODE_MAX);
  endfunction

  // Number of halvings of the slowest bit period.
  function automatic logic [2:0] rate_shift(input logic [7:0] code);
    logic [7:0] diff;
    diff = code - RATE_CODE_MIN;
    return diff[2:0];
  endfunction

endpackage

// File: rtl/ook_bit_timer.sv
module ook_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] shift,
  output logic       tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] last_cnt;

  // Terminal count: (2**DIV_W >> shift) - 1
  always_comb begin
    last_cnt = {DIV_W{1'b1}} >> shift;
    tick     = run && (cnt_q == last_cnt);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ook_shift_out.sv
module ook_shift_out #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  output logic         msb
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  always_comb begin
    if (load)     sr_d = load_val;
    else if (adv) sr_d = {sr_q[W-2:0], 1'b0};
    else          sr_d = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[W-1];

endmodule

// File: rtl/ook_wuc_tx.sv
module ook_wuc_tx
  import ook_wuc_pkg::*;
#(
  parameter int BASE_LOG2 = 8,
  parameter int PRE_LEN   = 16,
  parameter int ADDR_W    = 16,
  parameter int PAY_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      tgt_addr,
  input  logic [7:0]             rate_low,
  input  logic [7:0]             rate_fast,
  input  logic [7:0]             pay_flags,
  input  logic [PAY_BYTES*8-1:0] pay_data,
  output logic                   key_out,
  output logic                   busy,
  output logic                   done,
  output logic                   rate_err
);

  localparam int PAY_W   = PAY_BYTES * 8;
  localparam int FRAME_W = ADDR_W + PAY_W;
  localparam int MAX_AP  = (ADDR_W > PAY_W) ? ADDR_W : PAY_W;
  localparam int MAX_B   = (PRE_LEN > MAX_AP) ? PRE_LEN : MAX_AP;
  localparam int CNT_W   = $clog2(MAX_B + 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] PAY_LAST  = CNT_W'(PAY_W - 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [2:0]       lo_sh_q, lo_sh_d;
  logic [2:0]       hi_sh_q, hi_sh_d;
  logic             pay_en_q, pay_en_d;
  logic             done_q, done_d;
  logic             err_q, err_d;

  logic       codes_ok;
  logic       accept;
  logic       tick;
  logic       run;
  logic       sh_adv;
  logic       data_bit;
  logic [2:0] cur_shift;

  assign codes_ok  = rate_code_ok(rate_low) && rate_code_ok(rate_fast);
  assign accept    = (state_q == ST_IDLE) && start && codes_ok;
  assign run       = (state_q != ST_IDLE);
  assign cur_shift = (state_q == ST_PRE) ? lo_sh_q : hi_sh_q;
  assign sh_adv    = tick && ((state_q == ST_ADDR) || (state_q == ST_PAY));

  ook_bit_timer #(
    .DIV_W (BASE_LOG2)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .shift (cur_shift),
    .tick  (tick)
  );

  ook_shift_out #(
    .W (FRAME_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ({tgt_addr, pay_data}),
    .adv      (sh_adv),
    .msb      (data_bit)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    bcnt_d   = bcnt_q;
    lo_sh_d  = lo_sh_q;
    hi_sh_d  = hi_sh_q;
    pay_en_d = pay_en_q;
    done_d   = 1'b0;
    err_d    = (state_q == ST_IDLE) && start && !codes_ok;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_PRE;
          bcnt_d   = '0;
          lo_sh_d  = rate_shift(rate_low);
          hi_sh_d  = rate_shift(rate_fast);
          pay_en_d = pay_flags[0];
        end
      end
      ST_PRE: begin
        if (tick) begin
          if (bcnt_q == PRE_LAST) begin
            state_d = ST_ADDR;
            bcnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_ADDR: begin
        if (tick) begin
          if (bcnt_q == ADDR_LAST) begin
            bcnt_d = '0;
            if (pay_en_q) begin
              state_d = ST_PAY;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_PAY: begin
        if (tick) begin
          if (bcnt_q == PAY_LAST) begin
            state_d = ST_IDLE;
            bcnt_d  = '0;
            done_d  = 1'b1;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bcnt_q   <= '0;
      lo_sh_q  <= '0;
      hi_sh_q  <= '0;
      pay_en_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bcnt_q   <= bcnt_d;
      lo_sh_q  <= lo_sh_d;
      hi_sh_q  <= hi_sh_d;
      pay_en_q <= pay_en_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  // Preamble alternates starting with 1; the other sections come from the shifter.
  always_comb begin
    unique case (state_q)
      ST_PRE:           key_out = ~bcnt_q[0];
      ST_ADDR, ST_PAY:  key_out = data_bit;
      default:          key_out = 1'b0;
    endcase
  end

  assign busy     = run;
  assign done     = done_q;
  assign rate_err = err_q;

endmodule

// File: rtl/ook_wuc_tx_chk.sv
module ook_wuc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic key_out,
  input logic busy,
  input logic done,
  input logic rate_err
);

  assert_idle_key_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !key_out);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_err_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err |-> ($past(start) && !$past(busy) && !busy));

  assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_preamble_opens_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> key_out);

  assert_no_err_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rate_err);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind ook_wuc_tx ook_wuc_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .key_out  (key_out),
  .busy     (busy),
  .done     (done),
  .rate_err (rate_err)
);

// File: tb/tb_ook_wuc_tx.sv
module tb_ook_wuc_tx;

  localparam int BL2 = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] tgt_addr;
  logic [7:0]  rate_low;
  logic [7:0]  rate_fast;
  logic [7:0]  pay_flags;
  logic [47:0] pay_data;
  logic        key_out;
  logic        busy;
  logic        done;
  logic        rate_err;

  int checks = 0;
  int fails  = 0;
  int frames_done = 0;

  typedef struct {
    logic v;
    int   len;
  } bit_item_t;
  bit_item_t exp_q[$];

  always #2 clk = ~clk;

  ook_wuc_tx #(
    .BASE_LOG2 (BL2),
    .PRE_LEN   (16),
    .ADDR_W    (16),
    .PAY_BYTES (6)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tgt_addr  (tgt_addr),
    .rate_low  (rate_low),
    .rate_fast (rate_fast),
    .pay_flags (pay_flags),
    .pay_data  (pay_data),
    .key_out   (key_out),
    .busy      (busy),
    .done      (done),
    .rate_err  (rate_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int period(input logic [7:0] code);
    return (1 << BL2) >> (code - 8'h02);
  endfunction

  // Driver side: expected bit stream into the scoreboard queue
  task automatic push_frame(input logic [15:0] a, input logic [7:0] lo,
                            input logic [7:0] hi, input logic [7:0] fl,
                            input logic [47:0] pd);
    for (int i = 0; i < 16; i++) exp_q.push_back('{v: (i % 2 == 0), len: period(lo)});
    for (int i = 15; i >= 0; i--) exp_q.push_back('{v: a[i], len: period(hi)});
    if (fl[0])
      for (int i = 47; i >= 0; i--) exp_q.push_back('{v: pd[i], len: period(hi)});
  endtask

  task automatic pulse_start(input logic [15:0] a, input logic [7:0] lo,
                             input logic [7:0] hi, input logic [7:0] fl,
                             input logic [47:0] pd);
    tgt_addr = a; rate_low = lo; rate_fast = hi; pay_flags = fl; pay_data = pd;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_frame(input int old);
    while (frames_done == old) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic send_frame(input logic [15:0] a, input logic [7:0] lo,
                            input logic [7:0] hi, input logic [7:0] fl,
                            input logic [47:0] pd);
    int old;
    old = frames_done;
    push_frame(a, lo, hi, fl, pd);
    pulse_start(a, lo, hi, fl, pd);
    wait_frame(old);
  endtask

  task automatic try_bad(input logic [7:0] lo, input logic [7:0] hi);
    bit quiet;
    pulse_start(16'h1234, lo, hi, 8'h01, 48'hFFFF_FFFF_FFFF);
    @(negedge clk);
    check(rate_err && !busy, "R2", "error pulse after refused code", {busy, rate_err}, 1);
    quiet = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (busy || key_out || rate_err) quiet = 1'b0;
    end
    check(quiet, "R2", "nothing sent after refused code", !quiet, 0);
    #1;
  endtask

  // Monitor: pops expected bits as the design produces them
  int   hold_cnt = 0;
  bit   bit_bad  = 0;
  logic bad_val  = 0;
  logic prev_busy = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy = 1'b0;
      hold_cnt  = 0;
      bit_bad   = 0;
    end else begin
      if (busy) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", "key output beyond expected frame", key_out, 0);
        end else begin
          if (key_out !== exp_q[0].v && !bit_bad) begin
            bit_bad = 1'b1;
            bad_val = key_out;
          end
          hold_cnt++;
          if (hold_cnt == exp_q[0].len) begin
            check(!bit_bad, "R1/R3/R4/R5", "keyed bit value over its period",
                  bit_bad ? bad_val : exp_q[0].v, exp_q[0].v);
            void'(exp_q.pop_front());
            hold_cnt = 0;
            bit_bad  = 1'b0;
          end
        end
      end
      if (prev_busy && !busy) begin
        check(done && !key_out && exp_q.size() == 0, "R8",
              "done pulse and empty scoreboard at call end", exp_q.size(), 0);
        frames_done++;
      end else if (done) begin
        check(0, "R8", "stray done pulse", done, 0);
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WATCHDOG", "run did not complete", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tgt_addr = '0; rate_low = '0;
    rate_fast = '0; pay_flags = '0; pay_data = '0;
    repeat (3) @(negedge clk);
    check(!key_out && !busy && !done && !rate_err, "R9", "outputs in reset",
          {key_out, busy, done, rate_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!key_out && !busy && !done && !rate_err, "R9", "outputs after reset",
          {key_out, busy, done, rate_err}, 0);
    #1;

    // R1 R3: slow preamble, fastest address, no payload
    send_frame(16'hA5C3, 8'h02, 8'h07, 8'h00, 48'h0);
    // R4: reversed rates, payload requested
    send_frame(16'h8001, 8'h07, 8'h02, 8'h01, 48'hC3_5A_01_80_FF_00);
    // R4: flag bit 0 clear, other flag bits set, payload must be ignored
    send_frame(16'h0F0F, 8'h04, 8'h06, 8'hFE, 48'hFFFF_FFFF_FFFF);
    // R1: middle rates with payload
    send_frame(16'h7E81, 8'h03, 8'h05, 8'h81, 48'h12_34_56_78_9A_BC);

    // R2: refused codes on both sides of the range
    try_bad(8'h02, 8'h08);
    try_bad(8'h01, 8'h05);
    try_bad(8'h00, 8'h00);
    try_bad(8'hFF, 8'h03);

    // R7: starts during a call are ignored
    begin
      int old;
      old = frames_done;
      push_frame(16'h3C96, 8'h02, 8'h06, 8'h01, 48'hDE_AD_BE_EF_55_AA);
      pulse_start(16'h3C96, 8'h02, 8'h06, 8'h01, 48'hDE_AD_BE_EF_55_AA);
      repeat (30) @(negedge clk);
      #1;
      pulse_start(16'h0000, 8'h09, 8'h01, 8'h00, 48'h0);
      @(negedge clk);
      check(!rate_err && busy, "R7", "illegal start while busy", rate_err, 0);
      #1;
      pulse_start(16'hFFFF, 8'h07, 8'h07, 8'h00, 48'h0);
      @(negedge clk);
      check(busy && !rate_err, "R7", "legal start while busy", busy, 1);
      #1;
      wait_frame(old);
    end

    // R8: back-to-back call started in the done cycle
    send_frame(16'h5555, 8'h06, 8'h07, 8'h00, 48'h0);
    send_frame(16'hC001, 8'h05, 8'h07, 8'h01, 48'h01_02_04_08_10_20);

    repeat (5) @(negedge clk);
    check(!busy && !key_out && exp_q.size() == 0, "R5", "idle after all calls",
          exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule